// File: doc/BRIEF.md
# Serial ADC Strobe Sequencer

This block drives the start-convert line of a group of serial ADCs and collects the serial sample that comes back. A 24-bit pattern word is held in a local register. On every rising edge of the phase clock, the block takes a snapshot of that word. It then plays the snapshot onto the strobe line, highest bit first, advancing one bit on each rising edge of the ADC clock. The first 1 in the pattern makes the strobe rise, and that edge starts the conversion.

Returned data is sampled on the 24 ADC clock rising edges that follow the strobe's rise. The lowest pattern bit selects how the sample is aligned:
- **Plain mode** (pattern bit 0 = 0): the received bits are stored as they arrive.
- **Header mode** (pattern bit 0 = 1): the converter sends a few header bits before the sample. The block rotates those header bits into the bottom of the result, so the sample's MSB ends up at bit 23.

A valid pulse marks each finished word. Both clocks are level inputs sampled by the system clock `clk`. Rising edges are detected inside the block.

Top module: `adc_strobe_seq`

## Requirements
- R1: After reset, `strobe_o` and `adc_valid_o` are 0 and `adc_word_o` is 0. The pattern register resets to 0xFFFFFE, and a phase edge with no prior write plays that value.
- R2: A phase-clock rising edge snapshots the pattern register. The strobe then shows pattern bit 23 first and moves down one bit on each ADC-clock rising edge, down to bit 0.
- R3: Once the bit-0 interval ends, `strobe_o` stays 0 until the next phase-clock rising edge.
- R4: A write to the pattern register during a transfer does not change that transfer. It takes effect at the next phase-clock rising edge.
- R5: Receiving starts at the ADC-clock rising edge that ends the interval of the first 1 bit of the pattern. `sdata_i` is sampled on that edge and the next 23 ADC-clock rising edges. Its value at any other time has no effect on `adc_word_o`.
- R6: With pattern bit 0 = 0, the first received bit lands in `adc_word_o[23]` and the last one in bit 0.
- R7: With pattern bit 0 = 1, let z be the number of leading zeros of the pattern, capped at 4. Then h = 4 - z header bits are expected. The received word is rotated left by h, so the header occupies bits h-1:0 (first header bit at h-1) and the sample's MSB is at bit 23.
- R8: `adc_valid_o` is a single-cycle pulse, given once per completed 24-bit receive. `adc_word_o` changes only together with that pulse.
- R9: An all-zero pattern never raises the strobe, starts no receive and gives no valid pulse.
- R10: A phase-clock rising edge in the middle of a transfer restarts the strobe from bit 23 and discards the partly received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_clk_i | input | 1 | Phase clock level; a rising edge starts a transfer |
| adc_clk_i | input | 1 | ADC bit clock level; a rising edge advances and samples |
| word_we_i | input | 1 | Pattern register write enable |
| word_i | input | 24 | New pattern value |
| sdata_i | input | 1 | Serial data returned by the ADC |
| strobe_o | output | 1 | Strobe / start-convert line |
| adc_word_o | output | 24 | Assembled, aligned ADC word |
| adc_valid_o | output | 1 | One-cycle pulse when `adc_word_o` is updated |

## Verification
The assertions check the following on every cycle:
- the bit index loads to 23 on a phase edge and steps down by one per ADC edge;
- the strobe falls after bit 0;
- a receive starts only while the strobe is high, and never for an all-zero pattern;
- the valid pulse lasts one cycle and follows an active receive;
- the output word moves only with valid;
- a phase edge clears any receive in progress.

Only the bench's scenarios can show the rest:
- the strobe sequence bit for bit for each pattern;
- the exact header rotation for each leading-zero count;
- that data outside the sampling window is ignored;
- that a mid-transfer pattern write is deferred;
- that a restarted frame yields exactly one correct word.

// File: rtl/adcs_pkg.sv
`timescale 1ns/1ps
package adcs_pkg;
  localparam int unsigned DEF_WORD_W  = 24;
  localparam int unsigned DEF_HDR_MAX = 4;
  localparam logic [23:0] DEF_RESET_WORD = 24'hFFFFFE;

  typedef enum logic {TX_IDLE, TX_SHIFT} tx_state_e;
endpackage

// File: rtl/adcs_rst_sync.sv
`timescale 1ns/1ps
module adcs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/adcs_edge_det.sv
`timescale 1ns/1ps
module adcs_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d = lvl_i;
    rise_o = lvl_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/adcs_pattern_tx.sv
`timescale 1ns/1ps
module adcs_pattern_tx
  import adcs_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned HDR_MAX = DEF_HDR_MAX,
  localparam int unsigned IDX_W  = $clog2(WORD_W),
  localparam int unsigned HC_W   = $clog2(HDR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_rise_i,
  input  logic              adc_rise_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              strobe_o,
  output logic              rx_start_o,
  output logic              restart_o,
  output logic              hdr_mode_o,
  output logic [HC_W-1:0]   hdr_cnt_o
);
  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] pat_q, pat_d;
  logic              seen_q, seen_d;
  logic              hdr_mode_q, hdr_mode_d;
  logic [HC_W-1:0]   hdr_cnt_q, hdr_cnt_d;
  logic [HC_W-1:0]   lz_c;
  logic              lz_stop;
  logic              cur_bit;

  // leading zeros of the incoming pattern, capped at HDR_MAX
  always_comb begin
    lz_c    = '0;
    lz_stop = 1'b0;
    for (int i = 0; i < int'(HDR_MAX); i++) begin
      if (!lz_stop) begin
        if (word_i[WORD_W-1-i]) lz_stop = 1'b1;
        else                    lz_c    = lz_c + 1'b1;
      end
    end
  end

  assign cur_bit = pat_q[idx_q];

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    pat_d      = pat_q;
    seen_d     = seen_q;
    hdr_mode_d = hdr_mode_q;
    hdr_cnt_d  = hdr_cnt_q;
    rx_start_o = 1'b0;
    if (phase_rise_i) begin
      state_d    = TX_SHIFT;
      idx_d      = IDX_W'(WORD_W - 1);
      pat_d      = word_i;
      seen_d     = 1'b0;
      hdr_mode_d = word_i[0];
      hdr_cnt_d  = word_i[0] ? (HC_W'(HDR_MAX) - lz_c) : '0;
    end else if (state_q == TX_SHIFT && adc_rise_i) begin
      if (cur_bit && !seen_q) begin
        seen_d     = 1'b1;
        rx_start_o = 1'b1;
      end
      if (idx_q == '0) state_d = TX_IDLE;
      else             idx_d   = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      idx_q      <= '0;
      pat_q      <= '0;
      seen_q     <= 1'b0;
      hdr_mode_q <= 1'b0;
      hdr_cnt_q  <= '0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      pat_q      <= pat_d;
      seen_q     <= seen_d;
      hdr_mode_q <= hdr_mode_d;
      hdr_cnt_q  <= hdr_cnt_d;
    end
  end

  assign strobe_o   = (state_q == TX_SHIFT) & cur_bit;
  assign restart_o  = phase_rise_i;
  assign hdr_mode_o = hdr_mode_q;
  assign hdr_cnt_o  = hdr_cnt_q;

  // R2: a phase edge loads the top bit index
  p_load_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rise_i |=> (state_q == TX_SHIFT && idx_q == IDX_W'(WORD_W - 1)));
  // R2: one step down per ADC edge
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SHIFT && adc_rise_i && !phase_rise_i && idx_q != '0)
      |=> (idx_q == $past(idx_q) - 1'b1));
  // R3: strobe falls after the bit-0 interval
  p_low_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SHIFT && idx_q == '0 && adc_rise_i && !phase_rise_i) |=> !strobe_o);
  // R5: a receive starts only while the line is high
  p_start_on_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_o |-> strobe_o);
  // R9: an all-zero pattern never starts a receive
  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SHIFT && pat_q == '0) |-> !rx_start_o);
endmodule

// File: rtl/adcs_sample_rx.sv
`timescale 1ns/1ps
module adcs_sample_rx
  import adcs_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned HDR_MAX = DEF_HDR_MAX,
  localparam int unsigned HC_W   = $clog2(HDR_MAX + 1),
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_rise_i,
  input  logic              sdata_i,
  input  logic              start_i,
  input  logic              restart_i,
  input  logic              hdr_mode_i,
  input  logic [HC_W-1:0]   hdr_cnt_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d, sh_next;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v,
                                             input int unsigned h);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < int'(WORD_W); i++)
      r[i] = v[(i + int'(WORD_W) - int'(h)) % int'(WORD_W)];
    return r;
  endfunction

  assign sh_next = {sh_q[WORD_W-2:0], sdata_i};

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (restart_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
      sh_d   = sh_next;
    end else if (busy_q && adc_rise_i) begin
      sh_d = sh_next;
      if (cnt_q == CNT_W'(WORD_W - 1)) begin
        busy_d  = 1'b0;
        cnt_d   = '0;
        word_d  = hdr_mode_i ? rotl(sh_next, int'(hdr_cnt_i)) : sh_next;
        valid_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R8: single-cycle valid
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R8: valid only after an active receive
  p_valid_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(busy_q));
  // R5: sample count stays inside the word
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(WORD_W));
  // R10: a phase edge drops a partial receive
  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!busy_q && !valid_q));
endmodule

// File: rtl/adc_strobe_seq.sv
`timescale 1ns/1ps
module adc_strobe_seq
  import adcs_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned HDR_MAX = DEF_HDR_MAX,
  parameter logic [WORD_W-1:0] RESET_WORD = WORD_W'(DEF_RESET_WORD),
  localparam int unsigned HC_W   = $clog2(HDR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_clk_i,
  input  logic              adc_clk_i,
  input  logic              word_we_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sdata_i,
  output logic              strobe_o,
  output logic [WORD_W-1:0] adc_word_o,
  output logic              adc_valid_o
);
  localparam int unsigned N_EDGE = 2;

  logic              rst_sync_n;
  logic [N_EDGE-1:0] lvl, rise;
  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic              rx_start, restart, hdr_mode;
  logic [HC_W-1:0]   hdr_cnt;

  adcs_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign lvl = {adc_clk_i, phase_clk_i};

  for (genvar g = 0; g < int'(N_EDGE); g++) begin : g_edge
    adcs_edge_det u_det (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .lvl_i  (lvl[g]),
      .rise_o (rise[g])
    );
  end

  always_comb begin
    cfg_d = word_we_i ? word_i : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= RESET_WORD;
    else             cfg_q <= cfg_d;
  end

  adcs_pattern_tx #(.WORD_W(WORD_W), .HDR_MAX(HDR_MAX)) u_tx (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .phase_rise_i (rise[0]),
    .adc_rise_i   (rise[1]),
    .word_i       (cfg_q),
    .strobe_o     (strobe_o),
    .rx_start_o   (rx_start),
    .restart_o    (restart),
    .hdr_mode_o   (hdr_mode),
    .hdr_cnt_o    (hdr_cnt)
  );

  adcs_sample_rx #(.WORD_W(WORD_W), .HDR_MAX(HDR_MAX)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .adc_rise_i (rise[1]),
    .sdata_i    (sdata_i),
    .start_i    (rx_start),
    .restart_i  (restart),
    .hdr_mode_i (hdr_mode),
    .hdr_cnt_i  (hdr_cnt),
    .word_o     (adc_word_o),
    .valid_o    (adc_valid_o)
  );

  // R8: the output word moves only with the valid pulse
  p_word_on_valid_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(adc_word_o) |-> adc_valid_o);
endmodule

// File: tb/sim_adc_strobe_seq.sv
`timescale 1ns/1ps
module sim_adc_strobe_seq;
  logic        clk = 1'b0;
  logic        rst_n, phase_clk, adc_clk, word_we, sdata;
  logic [23:0] word_in;
  logic        strobe_o, adc_valid_o;
  logic [23:0] adc_word_o;

  int          n_chk = 0, n_fail = 0, vcnt = 0;
  logic [23:0] wlast = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  adc_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .phase_clk_i(phase_clk), .adc_clk_i(adc_clk),
    .word_we_i(word_we), .word_i(word_in), .sdata_i(sdata),
    .strobe_o(strobe_o), .adc_word_o(adc_word_o), .adc_valid_o(adc_valid_o)
  );

  // {pattern, serial stream sent MSB first}
  localparam logic [47:0] VEC [0:6] = '{
    48'hF0000F_A12345, 48'h3C0001_5A5A5A, 48'h7FFFFF_0F1E2D,
    48'h0FFFF1_C3C3C3, 48'h800000_123456, 48'h000001_9ABCDE,
    48'h00F0F0_FEDCBA
  };

  task automatic check(input bit ok, input string tag,
                       input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int first_one(input logic [23:0] p);
    for (int i = 23; i >= 0; i--) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [23:0] exp_word(input logic [23:0] p, input logic [23:0] s);
    int z = 0;
    int h;
    if (!p[0]) return s;
    for (int i = 23; i >= 20; i--) begin
      if (p[i]) break;
      z++;
    end
    h = 4 - z;
    if (h == 0) return s;
    return (s << h) | (s >> (24 - h));
  endfunction

  task automatic tick(input logic d);
    sdata   = d;
    adc_clk = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (adc_valid_o) begin
      vcnt++;
      wlast = adc_word_o;
    end
    adc_clk = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic phase_edge();
    phase_clk = 1'b1;
    @(posedge clk);
    @(negedge clk);
    phase_clk = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] w);
    word_we = 1'b1;
    word_in = w;
    @(posedge clk);
    @(negedge clk);
    word_we = 1'b0;
  endtask

  task automatic run_frame(input logic [23:0] p, input logic [23:0] s,
                           input bit mid_en, input logic [23:0] mid_w,
                           input string tag);
    int f, st, n, smis;
    logic es, d;
    f = first_one(p);
    st = (f < 0) ? 0 : 23 - f;
    n = st + 26;
    smis = 0;
    vcnt = 0;
    phase_edge();
    for (int j = 0; j < n; j++) begin
      es = (j < 24) ? p[23 - j] : 1'b0;
      if (strobe_o !== es) smis++;
      if (f >= 0 && j >= st && j < st + 24) d = s[23 - (j - st)];
      else d = (j % 2 == 0);
      if (mid_en && j == 5) wr(mid_w);
      tick(d);
    end
    check(smis == 0, {tag, " R2 R3 strobe mismatches"}, 24'(smis), 24'd0);
    check(vcnt == ((f < 0) ? 0 : 1), {tag, " R8 valid pulses"}, 24'(vcnt),
          24'((f < 0) ? 0 : 1));
    if (f >= 0)
      check(wlast === exp_word(p, s), {tag, " R5 word"}, wlast, exp_word(p, s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 24'd0, 24'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    rst_n = 1'b0; phase_clk = 1'b0; adc_clk = 1'b0;
    word_we = 1'b0; word_in = '0; sdata = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1: reset state
    check(strobe_o == 1'b0 && adc_valid_o == 1'b0, "R1 outputs after reset",
          {22'd0, strobe_o, adc_valid_o}, 24'd0);
    check(adc_word_o == 24'd0, "R1 word after reset", adc_word_o, 24'd0);
    // R1 R6: default pattern, plain mode
    run_frame(24'hFFFFFE, 24'h654321, 1'b0, '0, "R1 R6 default pattern");

    // table: R5 R6 R7 over several patterns
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][47:24]);
      run_frame(VEC[i][47:24], VEC[i][23:0], 1'b0, '0,
                VEC[i][24] ? "R7 header" : "R6 plain");
    end

    // R9: all-zero pattern, word held
    held = adc_word_o;
    wr(24'h000000);
    run_frame(24'h000000, 24'hFFFFFF, 1'b0, '0, "R9 zero pattern");
    check(adc_word_o === held, "R9 word held", adc_word_o, held);

    // R4: write during transfer is deferred
    wr(24'hA5A5A4);
    run_frame(24'hA5A5A4, 24'h13579B, 1'b1, 24'h0FFFF1, "R4 current frame");
    run_frame(24'h0FFFF1, 24'h2468AC, 1'b0, '0, "R4 next frame");

    // R10: restart mid-transfer
    wr(24'hF0000F);
    vcnt = 0;
    phase_edge();
    for (int j = 0; j < 10; j++) tick(1'b1);
    check(vcnt == 0, "R10 no valid before restart", 24'(vcnt), 24'd0);
    run_frame(24'hF0000F, 24'h3E1D07, 1'b0, '0, "R10 restarted frame");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule